// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Multiply and Divide

This block is the purely combinational execute unit of a small 32-bit integer core. It takes two operands and a 4-bit operation code and returns one result in the same cycle. It covers addition, subtraction, three shifts, signed less-than, the three bitwise operations, both halves of a multiply, and unsigned quotient and remainder.

The surrounding core handles everything else: choosing a register or an immediate as the second operand, evaluating branch conditions and writing the result back. Multiply and divide are fully unrolled. They are intended for a core that expects every operation to finish in a single cycle, and for the lower clock rate that this choice implies.

Top module: `rv_int_alu`

## Requirements
- R1: Operation code 0 returns a_i plus b_i, modulo 2^32.
- R2: Operation code 1 returns a_i minus b_i, modulo 2^32.
- R3: Operation code 2 shifts a_i left with zero fill. The shift distance is b_i[4:0], and the upper bits of b_i are ignored.
- R4: Operation code 3 shifts a_i right by b_i[4:0] with zero fill.
- R5: Operation code 4 shifts a_i right by b_i[4:0] and fills with copies of a_i[31].
- R6: Operation code 5 compares the operands as two's-complement numbers. It returns 1 in bit 0 when a_i < b_i and 0 otherwise, and all upper bits are zero.
- R7: Operation codes 6, 7 and 8 return the bitwise xor, or and and of the operands.
- R8: Operation code 9 returns bits 31:0 of the product a_i * b_i.
- R9: Operation code 10 returns bits 63:32 of the product with both operands taken as unsigned. For example, 0xFFFFFFFF times 2 gives 0x00000001.
- R10: Operation code 11 returns the unsigned quotient a_i / b_i. When b_i is 0, the result is 0xFFFFFFFF.
- R11: Operation code 12 returns the unsigned remainder a_i mod b_i. When b_i is 0, the result is a_i.
- R12: Operation codes 13, 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; its low 5 bits give the shift distance |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Result |

## Verification
The assertions are evaluated whenever an input changes. They check the following relationships:
- For every nonzero divisor, quotient times divisor plus remainder equals the dividend, and the remainder is smaller than the divisor.
- A zero divisor produces an all-ones quotient and a remainder equal to the dividend.
- A multiply by one passes the other operand through.
- Right shifts fill the top bit correctly for their kind.
- Two equal operands subtract to zero.
- A negative operand compared with a non-negative one gives a less-than result.

Only the bench shows the exact value of every operation across many operands. It also shows that unused operation codes return zero, that upper shift-distance bits are ignored, and where the unsigned high multiply differs from a signed one.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_SLL   = 4'd2,
    ALU_SRL   = 4'd3,
    ALU_SRA   = 4'd4,
    ALU_SLT   = 4'd5,
    ALU_XOR   = 4'd6,
    ALU_OR    = 4'd7,
    ALU_AND   = 4'd8,
    ALU_MUL   = 4'd9,
    ALU_MULHU = 4'd10,
    ALU_DIVU  = 4'd11,
    ALU_REMU  = 4'd12,
    ALU_RSV0  = 4'd13,
    ALU_RSV1  = 4'd14,
    ALU_RSV2  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic           left_i,
  input  logic           arith_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stg [0:SHW];
  logic         fill;

  // left shifts reuse the right shifter on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[SHW][W-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[W-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stg[k+1] = shamt_i[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end

  assign res_o = left_i ? rev_out : stg[SHW];

  always_comb begin
    // R5
    sra_fill_chk: assert (!(arith_i && !left_i && data_i[W-1]) || res_o[W-1])
      else $error("arithmetic shift lost sign fill");
    // R4
    srl_fill_chk: assert (!(!arith_i && !left_i && shamt_i != '0) || !res_o[W-1])
      else $error("logical right shift filled with one");
  end
endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc [0:W];
  logic [PW-1:0] a_ext;

  assign a_ext  = {{W{1'b0}}, a_i};
  assign acc[0] = '0;

  // unsigned shift-and-add array, one row per multiplier bit
  for (genvar i = 0; i < W; i++) begin : g_row
    assign acc[i+1] = acc[i] + (b_i[i] ? (a_ext << i) : '0);
  end

  assign lo_o = acc[W][W-1:0];
  assign hi_o = acc[W][PW-1:W];

  always_comb begin
    // R8
    mul_unit_chk: assert (!(b_i == {{(W-1){1'b0}}, 1'b1}) || (lo_o == a_i && hi_o == '0))
      else $error("multiply by one did not pass operand");
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0] part [0:W];
  logic [W:0]   dvs_ext;

  assign part[0] = '0;
  assign dvs_ext = {1'b0, dvs_i};

  // restoring division, MSB of the dividend first
  for (genvar j = 0; j < W; j++) begin : g_step
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;
    assign trial          = {part[j], dvd_i[W-1-j]};
    assign diff           = trial - dvs_ext;
    assign ge             = trial >= dvs_ext;
    assign quo_o[W-1-j]   = ge;
    assign part[j+1]      = ge ? diff[W-1:0] : trial[W-1:0];
  end

  assign rem_o = part[W];

  always_comb begin
    // R10 R11
    div_identity_chk: assert (dvs_i == '0 ||
      ({{W{1'b0}}, quo_o} * {{W{1'b0}}, dvs_i} + {{W{1'b0}}, rem_o}) == {{W{1'b0}}, dvd_i})
      else $error("quotient and remainder do not rebuild dividend");
    // R11
    rem_bound_chk: assert (dvs_i == '0 || rem_o < dvs_i)
      else $error("remainder not below divisor");
    // R10 R11
    div_zero_chk: assert (dvs_i != '0 || (quo_o == '1 && rem_o == dvd_i))
      else $error("divide by zero result wrong");
  end

  logic [PW-1:0] unused_pw;
  assign unused_pw = '0;
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
  import rv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o
);
  localparam int unsigned SHW = $clog2(W);

  alu_op_e      op;
  logic         sub_en;
  logic [W-1:0] sum, shf_res, mul_lo, mul_hi, quo, rem;
  logic         lt;

  assign op     = alu_op_e'(op_i);
  assign sub_en = (op == ALU_SUB) || (op == ALU_SLT);
  assign sum    = a_i + (b_i ^ {W{sub_en}}) + {{(W-1){1'b0}}, sub_en};
  assign lt     = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : sum[W-1];

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .data_i  (a_i),
    .shamt_i (b_i[SHW-1:0]),
    .left_i  (op == ALU_SLL),
    .arith_i (op == ALU_SRA),
    .res_o   (shf_res)
  );

  alu_mult #(.W(W)) u_mult (
    .a_i  (a_i),
    .b_i  (b_i),
    .lo_o (mul_lo),
    .hi_o (mul_hi)
  );

  alu_divider #(.W(W)) u_div (
    .dvd_i (a_i),
    .dvs_i (b_i),
    .quo_o (quo),
    .rem_o (rem)
  );

  always_comb begin
    unique case (op)
      ALU_ADD, ALU_SUB:          res_o = sum;
      ALU_SLL, ALU_SRL, ALU_SRA: res_o = shf_res;
      ALU_SLT:                   res_o = {{(W-1){1'b0}}, lt};
      ALU_XOR:                   res_o = a_i ^ b_i;
      ALU_OR:                    res_o = a_i | b_i;
      ALU_AND:                   res_o = a_i & b_i;
      ALU_MUL:                   res_o = mul_lo;
      ALU_MULHU:                 res_o = mul_hi;
      ALU_DIVU:                  res_o = quo;
      ALU_REMU:                  res_o = rem;
      default:                   res_o = '0;
    endcase
  end

  always_comb begin
    // R2
    sub_self_chk: assert (!(op == ALU_SUB && a_i == b_i) || res_o == '0)
      else $error("self subtract not zero");
    // R6
    slt_sign_chk: assert (!(op == ALU_SLT && a_i[W-1] && !b_i[W-1]) || res_o == 1)
      else $error("negative not below non-negative");
  end
endmodule

// File: tb/rv_int_alu_bench.sv
module rv_int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rv_int_alu u_rv_int_alu (.a_i(a), .b_i(b), .op_i(op), .res_o(res));

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [63:0] p;
    p = {32'd0, x} * {32'd0, y};
    case (o)
      4'd0:  return x + y;
      4'd1:  return x - y;
      4'd2:  return x << y[4:0];
      4'd3:  return x >> y[4:0];
      4'd4:  return $unsigned($signed(x) >>> y[4:0]);
      4'd5:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd6:  return x ^ y;
      4'd7:  return x | y;
      4'd8:  return x & y;
      4'd9:  return p[31:0];
      4'd10: return p[63:32];
      4'd11: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      4'd12: return (y == 0) ? x : x % y;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";   4'd1: return "R2";   4'd2: return "R3";
      4'd3: return "R4";   4'd4: return "R5";   4'd5: return "R6";
      4'd6, 4'd7, 4'd8: return "R7";
      4'd9: return "R8";   4'd10: return "R9";  4'd11: return "R10";
      4'd12: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] e;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    e = model(o, x, y);
    n_vec++;
    if (res !== e) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h got=%h exp=%h", tag(o), o, x, y, res, e);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7121);
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (res !== 32'd0) begin
      n_bad++;
      $display("FAIL R1 reset-state got=%h exp=%h", res, 32'd0);
    end
    rst_n = 1'b1;
    check(4'd0, 32'hFFFF_FFFF, 32'd1);          // R1 wrap
    check(4'd1, 32'd0, 32'd1);                  // R2 borrow
    check(4'd1, 32'h1234_5678, 32'h1234_5678);  // R2
    check(4'd2, 32'd1, 32'd31);                 // R3
    check(4'd2, 32'hA5A5_0001, 32'h0000_0020);  // R3 upper bits ignored
    check(4'd2, 32'h0000_0003, 32'hFFFF_FFE4);  // R3
    check(4'd3, 32'h8000_0000, 32'd31);         // R4
    check(4'd4, 32'h8000_0000, 32'd31);         // R5
    check(4'd4, 32'h7000_0000, 32'd4);          // R5 positive
    check(4'd5, 32'hFFFF_FFFF, 32'd1);          // R6
    check(4'd5, 32'd1, 32'hFFFF_FFFF);          // R6
    check(4'd5, 32'd9, 32'd9);                  // R6 equal
    check(4'd5, 32'h8000_0000, 32'h7FFF_FFFF);  // R6 overflow case
    check(4'd6, 32'hF0F0_F0F0, 32'hFF00_FF00);  // R7
    check(4'd7, 32'hF0F0_F0F0, 32'h0F00_000F);  // R7
    check(4'd8, 32'hF0F0_F0F0, 32'hFF00_FF00);  // R7
    check(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R8
    check(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9
    check(4'd10, 32'hFFFF_FFFF, 32'd2);         // R9 unsigned view
    check(4'd11, 32'd7, 32'd2);                 // R10
    check(4'd11, 32'd3, 32'd9);                 // R10
    check(4'd11, 32'hDEAD_BEEF, 32'd0);         // R10 zero divisor
    check(4'd12, 32'd7, 32'd2);                 // R11
    check(4'd12, 32'hDEAD_BEEF, 32'd0);         // R11 zero divisor
    check(4'd11, 32'hFFFF_FFFF, 32'h8000_0000); // R10
    check(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R12
    check(4'd14, 32'h1234_5678, 32'd5);         // R12
    check(4'd15, 32'h8000_0001, 32'd1);         // R12
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 7 == 0) y = y & 32'h0000_00FF;
      if (i % 11 == 0) y = '0;
      check(4'($urandom % 16), x, y);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog timeout got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule